// File: doc/BRIEF.md
# Packed Colour Palette Memory

This block holds a 256-entry colour palette for a display pipeline. The palette sits in 128 words of 32 bits. Each word carries two 16-bit colour entries, so one word write sets the even entry and the odd entry that follows it. Each 16-bit entry has three 5-bit colour channels and one intensity bit. The intensity bit is stored, but it plays no part in the colour that comes out.

The block has two ports. On the register-bus port, software writes whole words and reads them back exactly as stored. The word is chosen by address bits 8:2, and address decoding outside the palette window is done upstream. On the lookup port, the pixel path presents an 8-bit index on every cycle. One cycle later it receives 8-bit red, green and blue, each made by shifting the 5-bit channel field left by three.

Both read paths are registered. When a write and a read hit the same word in the same cycle, the read returns the value held before that write.

Top module: `packed_palette_ram`

## Requirements
- R1: A bus write with `bus_wr_en` high stores all 32 bits of `bus_wdata` into the word selected by `bus_addr[8:2]`. There are 128 independent words.
- R2: A bus read with `bus_rd_en` high returns the raw stored word on `bus_rdata` after the next rising edge, intensity bits included. While `bus_rd_en` is low, `bus_rdata` holds its value.
- R3: Lookup index i maps to word i[7:1]. When i[0] is 0 the entry is bits 15:0 of that word; when i[0] is 1 it is bits 31:16.
- R4: Within an entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10.
- R5: Each colour output equals its 5-bit field shifted left by three, so its bits 2:0 are zero.
- R6: Entry bit 15 (intensity) has no effect on any colour output.
- R7: The colour for the index presented before a rising edge appears after that edge. A new index may be given every cycle.
- R8: A lookup and a write to the same word in the same cycle return the old colour. The next lookup returns the new colour.
- R9: A bus read and a bus write to the same word in the same cycle return the old word.
- R10: While `rst_n` is low, `bus_rdata` and all three colour outputs are zero.
- R11: Address bits 1:0 are ignored, so every byte offset within a word reaches the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Word write strobe |
| bus_rd_en | input | 1 | Word read strobe |
| bus_addr | input | 9 | Byte address inside the palette window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered raw read data |
| lk_idx | input | 8 | Pixel palette index |
| lk_red | output | 8 | Red result, one cycle after the index |
| lk_green | output | 8 | Green result, one cycle after the index |
| lk_blue | output | 8 | Blue result, one cycle after the index |

## Verification
The palette is filled twice with a scrambled word pattern. In the first pass every intensity bit is cleared, and in the second pass every intensity bit is set. Then all 256 indices are swept back-to-back with a new index on every cycle. This tells apart even and odd halves, each channel field, one-cycle timing and any leakage from the intensity bit, because a mix-up in any of them gives a different value for some index. All 128 words are read back raw after both fills, so a lost intensity bit or an aliased word index would show up. Same-cycle write/read and write/lookup collisions, reads at different byte offsets, and read-data hold are tried on their own.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Colour channel order inside one packed entry, lowest field first.
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    localparam int NUM_CH = 3;

endpackage

// File: rtl/pal_store.sv
module pal_store #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              a_en,
    input  logic [AW-1:0]     a_addr,
    output logic [WORD_W-1:0] a_data,
    input  logic [AW-1:0]     b_addr,
    output logic [WORD_W-1:0] b_data
);

    logic [WORD_W-1:0] mem [WORDS];

    // Array write; read registers below sample the pre-write contents.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_data <= '0;
            b_data <= '0;
        end else begin
            if (a_en) begin
                a_data <= mem[a_addr];
            end
            b_data <= mem[b_addr];
        end
    end

endmodule

// File: rtl/pal_entry_decode.sv
module pal_entry_decode
    import pal_pkg::*;
#(
    parameter int CH_W   = 5,
    parameter int OUT_W  = 8,
    localparam int ENT_W = NUM_CH * CH_W + 1,
    localparam int PAD_W = OUT_W - CH_W
) (
    input  logic [ENT_W-1:0]             entry,
    output logic [NUM_CH-1:0][OUT_W-1:0] colour
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign colour[c] = {entry[c*CH_W +: CH_W], {PAD_W{1'b0}}};
    end

    // Top bit of each entry is intensity; deliberately not decoded.
    logic unused_intensity;
    assign unused_intensity = entry[ENT_W-1];

endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
    import pal_pkg::*;
#(
    parameter int WORDS   = 128,
    parameter int CH_W    = 5,
    parameter int OUT_W   = 8,
    localparam int ENT_W  = NUM_CH * CH_W + 1,
    localparam int WORD_W = 2 * ENT_W,
    localparam int AW     = $clog2(WORDS),
    localparam int IW     = AW + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IW-1:0]                idx,
    output logic [AW-1:0]                word_addr,
    input  logic [WORD_W-1:0]            word_q,
    output logic [NUM_CH-1:0][OUT_W-1:0] colour
);

    logic             half_q;
    logic [ENT_W-1:0] entry;

    assign word_addr = idx[IW-1:1];

    // Half select travels alongside the registered word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= idx[0];
        end
    end

    assign entry = half_q ? word_q[WORD_W-1:ENT_W] : word_q[ENT_W-1:0];

    pal_entry_decode #(
        .CH_W  (CH_W),
        .OUT_W (OUT_W)
    ) u_dec (
        .entry  (entry),
        .colour (colour)
    );

endmodule

// File: rtl/packed_palette_ram.sv
module packed_palette_ram
    import pal_pkg::*;
#(
    parameter int WORDS   = 128,
    parameter int CH_W    = 5,
    parameter int OUT_W   = 8,
    localparam int ENT_W  = NUM_CH * CH_W + 1,
    localparam int WORD_W = 2 * ENT_W,
    localparam int AW     = $clog2(WORDS),
    localparam int BA_W   = AW + 2,
    localparam int IW     = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [BA_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [IW-1:0]     lk_idx,
    output logic [OUT_W-1:0]  lk_red,
    output logic [OUT_W-1:0]  lk_green,
    output logic [OUT_W-1:0]  lk_blue
);

    logic [AW-1:0]                word_sel;
    logic [AW-1:0]                lk_word;
    logic [WORD_W-1:0]            lk_word_q;
    logic [NUM_CH-1:0][OUT_W-1:0] colour;
    logic                         unused_byte_lanes;

    assign word_sel          = bus_addr[BA_W-1:2];
    assign unused_byte_lanes = ^bus_addr[1:0];

    pal_store #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_addr (word_sel),
        .wr_data (bus_wdata),
        .a_en    (bus_rd_en),
        .a_addr  (word_sel),
        .a_data  (bus_rdata),
        .b_addr  (lk_word),
        .b_data  (lk_word_q)
    );

    pal_lookup #(
        .WORDS (WORDS),
        .CH_W  (CH_W),
        .OUT_W (OUT_W)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (lk_idx),
        .word_addr (lk_word),
        .word_q    (lk_word_q),
        .colour    (colour)
    );

    assign lk_red   = colour[CH_RED];
    assign lk_green = colour[CH_GREEN];
    assign lk_blue  = colour[CH_BLUE];

    // Cycles-since-reset counter so history-based checks start clean.
    logic [1:0] live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (live_q != 2'd3) begin
            live_q <= live_q + 2'd1;
        end
    end

    // R2: read data holds when no read is requested
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && !bus_rd_en) |=> $stable(bus_rdata));

    // R2: repeated read of an unchanged word returns the same data
    p_reread_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && bus_rd_en && $past(bus_rd_en) && !$past(bus_wr_en)
         && $stable(word_sel)) |=> $stable(bus_rdata));

    // R1: a word written one cycle earlier reads back intact
    p_write_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && $past(bus_wr_en) && !bus_wr_en && bus_rd_en
         && word_sel == $past(word_sel)) |=> bus_rdata == $past(bus_wdata, 2));

    // R7: steady index with no write in between gives a steady colour
    p_lookup_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && $stable(lk_idx) && !$past(bus_wr_en))
        |=> $stable({lk_red, lk_green, lk_blue}));

endmodule

// File: tb/sim_packed_palette_ram.sv
module sim_packed_palette_ram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lk_idx = '0;
    logic [7:0]  lk_red, lk_green, lk_blue;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    packed_palette_ram u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lk_idx    (lk_idx),
        .lk_red    (lk_red),
        .lk_green  (lk_green),
        .lk_blue   (lk_blue)
    );

    function automatic logic [31:0] pattern(int n);
        return (n * 32'h9E3779B1) ^ (n << 7) ^ 32'h5A5A_3C3C;
    endfunction

    function automatic logic [23:0] colour_of(logic [31:0] w, int i);
        logic [15:0] e;
        e = i[0] ? w[31:16] : w[15:0];
        return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a[8:0];
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(int a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd_en = 1'b1;
        bus_addr  = a[8:0];
        @(negedge clk);
        bus_rd_en = 1'b0;
        check(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    // Back-to-back sweep of every index against a shadow image.
    task automatic sweep(logic [31:0] img [128], string tag);
        logic [23:0] got;
        logic [23:0] want;
        for (int i = 0; i <= 256; i++) begin
            @(negedge clk);
            if (i > 0) begin
                got  = {lk_red, lk_green, lk_blue};
                want = colour_of(img[(i-1) >> 1], i - 1);
                check(got === want, tag, {8'h0, got}, {8'h0, want});
            end
            if (i < 256) lk_idx = i[7:0];
        end
    endtask

    logic [31:0] img [128];

    initial begin
        logic [31:0] old_w;
        logic [31:0] new_w;
        logic [31:0] held;
        logic [23:0] got;

        repeat (3) @(negedge clk);
        check(bus_rdata === 32'h0, "R10 rdata", bus_rdata, 32'h0);
        check({lk_red, lk_green, lk_blue} === 24'h0, "R10 colour",
              {8'h0, lk_red, lk_green, lk_blue}, 32'h0);
        rst_n = 1'b1;

        // Pass A: intensity bits clear
        for (int n = 0; n < 128; n++) begin
            img[n] = pattern(n) & 32'h7FFF_7FFF;
            bus_write(n * 4, img[n]);
        end
        for (int n = 0; n < 128; n++) bus_read(n * 4, img[n], "R1 R2 readback A");
        sweep(img, "R3 R4 R5 R7 sweep A");

        // Pass B: same colours, intensity bits set
        for (int n = 0; n < 128; n++) begin
            img[n] = img[n] | 32'h8000_8000;
            bus_write(n * 4, img[n]);
        end
        for (int n = 0; n < 128; n++) bus_read(n * 4, img[n], "R2 raw intensity B");
        sweep(img, "R6 sweep B");

        // R11: byte offsets within a word
        bus_write(37 * 4 + 3, 32'hC0DE_1234);
        img[37] = 32'hC0DE_1234;
        bus_read(37 * 4 + 1, 32'hC0DE_1234, "R11 offset 1");
        bus_read(37 * 4 + 2, 32'hC0DE_1234, "R11 offset 2");

        // R2: hold while rd low and address moves
        held = bus_rdata;
        @(negedge clk);
        bus_addr = 9'd8;
        @(negedge clk);
        check(bus_rdata === held, "R2 hold", bus_rdata, held);

        // R8 R9: collision in one cycle on word 5 (entries 10/11)
        old_w = img[5];
        new_w = 32'h1357_9BDF;
        @(negedge clk);
        bus_wr_en = 1'b1; bus_rd_en = 1'b1;
        bus_addr  = 9'd20; bus_wdata = new_w;
        lk_idx    = 8'd11;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0;
        check(bus_rdata === old_w, "R9 read old", bus_rdata, old_w);
        got = {lk_red, lk_green, lk_blue};
        check(got === colour_of(old_w, 11), "R8 lookup old",
              {8'h0, got}, {8'h0, colour_of(old_w, 11)});
        @(negedge clk);
        got = {lk_red, lk_green, lk_blue};
        check(got === colour_of(new_w, 11), "R8 lookup new",
              {8'h0, got}, {8'h0, colour_of(new_w, 11)});
        bus_read(20, new_w, "R9 read new");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule